// File: doc/BRIEF.md
# Mailbox Message Sequencer

This block sends one command at a time to a power-management controller. The controller is reached through three mailbox words on a simple register bus: a response word, a parameter word and a message-ID word. A client hands over a message ID and a 32-bit argument on a valid/ready port.

The sequencer first waits until the response word stops reading as busy, where busy is the value zero. It then clears the response word and writes the argument. Last it writes the message ID, and that write is what starts the controller's work. After that it polls the response word until the controller posts a nonzero code. The number of reads is bounded, and the poller waits a programmable time between reads. When the command finishes, the block raises a single done pulse. With it come an 8-bit status and a 32-bit reply, and the reply is the parameter word read back.

The abort, failure and timeout paths follow fixed rules. A failure code is acknowledged by writing OK back into the response word. A completion poll that runs out of retries gets one more full pass. Message IDs outside the accepted range are refused locally and cause no bus access. A debug input removes the retry bound altogether.

Top module: `mbox_seq`

## Requirements
- R1: `reqReady` is high in idle and after reset, with `doneOut` and `busReq` low. A request is accepted on a cycle where `reqValid` and `reqReady` are both high. `reqReady` then stays low until `doneOut` has been high for exactly one cycle, and `statusOut` and `replyOut` are valid during that cycle.
- R2: A message ID of 0, or of 0x1E or above, completes with status 0xFE and reply 0. It makes no bus read and no bus write.
- R3: Before sending, the block reads the response word at address 0 until it is nonzero. Any nonzero value lets the send go ahead, not only OK (1).
- R4: A poll pass makes at most RETRIES+1 reads. If all of the readiness reads return 0, the request ends with status 0x00 and reply 0, and nothing is written.
- R5: A send consists of exactly three writes in this order: 0 to address 0, the argument to address 1, and the message ID zero-extended to address 2.
- R6: The completion poll stops at the first nonzero read of address 0. A nonzero value on the last allowed read counts as completion, not as a timeout.
- R7: Consecutive reads within one poll pass are DELAY_US*cyclesPerUs+2 clock cycles apart. That is the wait time plus the two-cycle read.
- R8: If the completion poll exhausts its reads, one further full pass follows at once. Status is then the low byte of the last response read, and reply is address 1 read back.
- R9: If the completion response is 0xFF, the block writes 1 to address 0, does not read address 1, and reports status 0xFF with reply 0.
- R10: For any other nonzero completion response (OK = 0x01, or the rejection codes 0xFE, 0xFD, 0xFC), status is its low byte and reply is the value of address 1 read after completion.
- R11: While `noTimeout` is high, both polls go on past RETRIES+1 reads until a nonzero value is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Sequencer idle, request may be accepted |
| reqId | input | MSG_W | Message ID |
| reqParam | input | DATA_W | Message argument |
| cyclesPerUs | input | CPU_W | Clock cycles per microsecond for the poll interval |
| noTimeout | input | 1 | Debug: poll without a retry bound |
| doneOut | output | 1 | One-cycle completion pulse |
| statusOut | output | 8 | Completion status code |
| replyOut | output | DATA_W | Reply (parameter word read back) |
| busReq | output | 1 | Bus access request, held until acknowledged |
| busWrite | output | 1 | 1 = write, 0 = read |
| busAddr | output | 2 | Mailbox word: 0 response, 1 parameter, 2 message ID |
| busWdata | output | DATA_W | Write data |
| busAck | input | 1 | Access complete; read data valid in this cycle |
| busRdata | input | DATA_W | Read data |

## Verification
The sharp corner is the cycle in which the retry limit is reached and the controller's answer appears on that same read. There, completion and timeout compete for the same state transition. The bench models the controller with a counter that answers on a chosen read number. It places the answer exactly on read RETRIES+1 of the readiness poll and of the completion poll, and then on read RETRIES+2, which falls into the extra pass. Each case is judged by how many response reads the bus model counted, by the writes it saw, and by the status and reply that come with the done pulse.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_POLL, S_GAP, S_CLR, S_PAR, S_ID, S_ACKF, S_REPLY, S_DONE
  } state_t;

  typedef enum logic [1:0] {PH_PRE, PH_POST, PH_EXTRA} phase_t;

  typedef enum logic [1:0] {WD_ZERO, WD_OK, WD_PARAM, WD_MSG} wsel_t;

  typedef struct packed {
    logic  capture;
    logic  badId;
    logic  loadGap;
    logic  tickGap;
    logic  clrRetry;
    logic  incRetry;
    logic  capResp;
    logic  capReply;
    wsel_t wdSel;
  } strobe_t;

  localparam logic [1:0] ADDR_RESP  = 2'd0;
  localparam logic [1:0] ADDR_PARAM = 2'd1;
  localparam logic [1:0] ADDR_MSG   = 2'd2;

  localparam logic [7:0] RESP_OK      = 8'h01;
  localparam logic [7:0] RESP_FAIL    = 8'hFF;
  localparam logic [7:0] RESP_UNKNOWN = 8'hFE;

  localparam int MSG_ID_LAST = 29;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int MSG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [MSG_W-1:0] reqId,
  input  logic             noTimeout,
  input  logic             busAck,
  input  logic             rdNonZero,
  input  logic             rdIsFail,
  input  logic             gapDone,
  input  logic             retryLast,
  output strobe_t          stb,
  output logic             busReq,
  output logic             busWrite,
  output logic [1:0]       busSel,
  output logic             reqReady,
  output logic             doneOut
);
  state_t state, stateNxt;
  phase_t phase, phaseNxt;
  logic   idBad;

  assign idBad = (reqId == '0) || (reqId > MSG_W'(MSG_ID_LAST));

  always_comb begin
    stb      = '0;
    busReq   = 1'b0;
    busWrite = 1'b0;
    busSel   = ADDR_RESP;
    stateNxt = state;
    phaseNxt = phase;
    case (state)
      S_IDLE: if (reqValid) begin
        stb.capture  = 1'b1;
        stb.clrRetry = 1'b1;
        if (idBad) begin
          stb.badId = 1'b1;
          stateNxt  = S_DONE;
        end else begin
          phaseNxt = PH_PRE;
          stateNxt = S_POLL;
        end
      end
      S_POLL: begin
        busReq = 1'b1;
        busSel = ADDR_RESP;
        if (busAck) begin
          stb.capResp = 1'b1;
          if (rdNonZero) begin
            if (phase == PH_PRE) stateNxt = S_CLR;
            else if (rdIsFail)   stateNxt = S_ACKF;
            else                 stateNxt = S_REPLY;
          end else if (retryLast && !noTimeout) begin
            case (phase)
              PH_PRE:  stateNxt = S_DONE;
              PH_POST: begin
                phaseNxt     = PH_EXTRA;
                stb.clrRetry = 1'b1;
                stateNxt     = S_POLL;
              end
              default: stateNxt = S_REPLY;
            endcase
          end else begin
            stb.loadGap = 1'b1;
            stateNxt    = S_GAP;
          end
        end
      end
      S_GAP: begin
        stb.tickGap = 1'b1;
        if (gapDone) begin
          stb.incRetry = 1'b1;
          stateNxt     = S_POLL;
        end
      end
      S_CLR: begin
        busReq = 1'b1; busWrite = 1'b1; busSel = ADDR_RESP; stb.wdSel = WD_ZERO;
        if (busAck) stateNxt = S_PAR;
      end
      S_PAR: begin
        busReq = 1'b1; busWrite = 1'b1; busSel = ADDR_PARAM; stb.wdSel = WD_PARAM;
        if (busAck) stateNxt = S_ID;
      end
      S_ID: begin
        busReq = 1'b1; busWrite = 1'b1; busSel = ADDR_MSG; stb.wdSel = WD_MSG;
        if (busAck) begin
          stb.clrRetry = 1'b1;
          phaseNxt     = PH_POST;
          stateNxt     = S_POLL;
        end
      end
      S_ACKF: begin
        busReq = 1'b1; busWrite = 1'b1; busSel = ADDR_RESP; stb.wdSel = WD_OK;
        if (busAck) stateNxt = S_DONE;
      end
      S_REPLY: begin
        busReq = 1'b1; busSel = ADDR_PARAM;
        if (busAck) begin
          stb.capReply = 1'b1;
          stateNxt     = S_DONE;
        end
      end
      S_DONE:  stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      phase <= PH_PRE;
    end else begin
      state <= stateNxt;
      phase <= phaseNxt;
    end
  end

  assign reqReady = (state == S_IDLE);
  assign doneOut  = (state == S_DONE);

  // R1: done is a single-cycle pulse followed by idle
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut && reqReady);

  // R5: a bus request holds its address and direction until acknowledged
  a_r5_bus_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> busReq && $stable(busSel) && $stable(busWrite));
endmodule

// File: rtl/mbox_dp.sv
module mbox_dp
  import mbox_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int MSG_W    = 8,
  parameter int CPU_W    = 8,
  parameter int RETRIES  = 2000000,
  parameter int DELAY_US = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [MSG_W-1:0]  reqId,
  input  logic [DATA_W-1:0] reqParam,
  input  logic [CPU_W-1:0]  cyclesPerUs,
  input  logic [DATA_W-1:0] busRdata,
  output logic              rdNonZero,
  output logic              rdIsFail,
  output logic              gapDone,
  output logic              retryLast,
  output logic [DATA_W-1:0] busWdata,
  output logic [7:0]        statusOut,
  output logic [DATA_W-1:0] replyOut
);
  localparam int GAP_W = CPU_W + $clog2(DELAY_US + 1);
  localparam int RTY_W = $clog2(RETRIES + 1);

  logic [MSG_W-1:0]  msgReg;
  logic [DATA_W-1:0] paramReg;
  logic [7:0]        respReg;
  logic [DATA_W-1:0] replyReg;
  logic [GAP_W-1:0]  gapCnt;
  logic [GAP_W-1:0]  gapLoad;
  logic [RTY_W-1:0]  retryCnt;

  assign gapLoad   = GAP_W'(DELAY_US) * GAP_W'(cyclesPerUs);
  assign rdNonZero = |busRdata;
  assign rdIsFail  = (busRdata == DATA_W'(RESP_FAIL));
  assign gapDone   = (gapCnt <= GAP_W'(1));
  assign retryLast = (retryCnt == RTY_W'(RETRIES));

  always_comb begin
    case (stb.wdSel)
      WD_ZERO:  busWdata = '0;
      WD_OK:    busWdata = DATA_W'(RESP_OK);
      WD_PARAM: busWdata = paramReg;
      default:  busWdata = DATA_W'(msgReg);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgReg   <= '0;
      paramReg <= '0;
      respReg  <= '0;
      replyReg <= '0;
    end else begin
      if (stb.capture) begin
        msgReg   <= reqId;
        paramReg <= reqParam;
        replyReg <= '0;
      end
      if (stb.badId)    respReg  <= RESP_UNKNOWN;
      if (stb.capResp)  respReg  <= busRdata[7:0];
      if (stb.capReply) replyReg <= busRdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt   <= '0;
      retryCnt <= '0;
    end else begin
      if (stb.loadGap)                 gapCnt <= gapLoad;
      else if (stb.tickGap && !gapDone) gapCnt <= gapCnt - GAP_W'(1);
      if (stb.clrRetry)                retryCnt <= '0;
      else if (stb.incRetry && !retryLast) retryCnt <= retryCnt + RTY_W'(1);
    end
  end

  assign statusOut = respReg;
  assign replyOut  = replyReg;

  // R4: the per-pass read counter never passes the retry bound
  a_r4_retry_bound: assert property (@(posedge clk) disable iff (!rstN)
    retryCnt <= RTY_W'(RETRIES));
endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
  import mbox_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int MSG_W    = 8,
  parameter int CPU_W    = 8,
  parameter int RETRIES  = 2000000,
  parameter int DELAY_US = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [MSG_W-1:0]  reqId,
  input  logic [DATA_W-1:0] reqParam,
  input  logic [CPU_W-1:0]  cyclesPerUs,
  input  logic              noTimeout,
  output logic              doneOut,
  output logic [7:0]        statusOut,
  output logic [DATA_W-1:0] replyOut,
  output logic              busReq,
  output logic              busWrite,
  output logic [1:0]        busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busAck,
  input  logic [DATA_W-1:0] busRdata
);
  strobe_t stb;
  logic    rdNonZero, rdIsFail, gapDone, retryLast;

  mbox_ctrl #(.MSG_W(MSG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqId(reqId),
    .noTimeout(noTimeout), .busAck(busAck), .rdNonZero(rdNonZero),
    .rdIsFail(rdIsFail), .gapDone(gapDone), .retryLast(retryLast),
    .stb(stb), .busReq(busReq), .busWrite(busWrite), .busSel(busAddr),
    .reqReady(reqReady), .doneOut(doneOut)
  );

  mbox_dp #(
    .DATA_W(DATA_W), .MSG_W(MSG_W), .CPU_W(CPU_W),
    .RETRIES(RETRIES), .DELAY_US(DELAY_US)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqId(reqId), .reqParam(reqParam),
    .cyclesPerUs(cyclesPerUs), .busRdata(busRdata), .rdNonZero(rdNonZero),
    .rdIsFail(rdIsFail), .gapDone(gapDone), .retryLast(retryLast),
    .busWdata(busWdata), .statusOut(statusOut), .replyOut(replyOut)
  );

  // R2: an out-of-range ID completes next cycle with 0xFE and no bus access
  a_r2_bad_id: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && (reqId == '0 || reqId > MSG_W'(MSG_ID_LAST)))
      |=> doneOut && !busReq && statusOut == RESP_UNKNOWN);

  // R9: the OK write-back to the response word only follows a failure code
  a_r9_fail_writeback: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWrite && busAddr == ADDR_RESP && busWdata == DATA_W'(RESP_OK))
      |-> statusOut == RESP_FAIL);

  // R5: the message-ID write directly follows the acknowledged parameter write
  a_r5_id_after_param: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWrite && busAddr == ADDR_MSG && !$past(busReq && busAddr == ADDR_MSG))
      |-> $past(busReq && busWrite && busAddr == ADDR_PARAM && busAck));
endmodule

// File: tb/sim_mbox_seq.sv
module sim_mbox_seq;
  localparam int RETRIES  = 3;
  localparam int DELAY_US = 2;
  localparam int CPU      = 3;
  localparam int GAP      = DELAY_US * CPU;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [7:0]  reqId = '0;
  logic [31:0] reqParam = '0;
  logic        noTimeout = 1'b0;
  logic        doneOut;
  logic [7:0]  statusOut;
  logic [31:0] replyOut;
  logic        busReq, busWrite;
  logic [1:0]  busAddr;
  logic [31:0] busWdata;
  logic        busAck = 1'b0;
  logic [31:0] busRdata = '0;

  int checks = 0;
  int failures = 0;

  // mailbox and controller model
  int          cyc = 0;
  int          rdCount = 0, wrCount = 0;
  int          rdCyc [0:31];
  logic [1:0]  wrAddr [0:7];
  logic [31:0] wrData [0:7];
  logic [31:0] mResp = 32'd1, mPar = '0;
  int          preArm = 0, postArm = 0, postK = 0;
  logic [31:0] preVal = '0, fwResp = '0, fwReply = '0;

  always #2.5 clk = ~clk;

  mbox_seq #(.RETRIES(RETRIES), .DELAY_US(DELAY_US)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqId(reqId), .reqParam(reqParam), .cyclesPerUs(8'(CPU)),
    .noTimeout(noTimeout), .doneOut(doneOut), .statusOut(statusOut),
    .replyOut(replyOut), .busReq(busReq), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busAck(busAck),
    .busRdata(busRdata)
  );

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rstN) begin
      busAck <= 1'b0;
    end else begin
      busAck <= busReq && !busAck;
      if (busReq && !busAck) begin
        if (busWrite) begin
          if (wrCount < 8) begin
            wrAddr[wrCount] = busAddr;
            wrData[wrCount] = busWdata;
          end
          wrCount = wrCount + 1;
          case (busAddr)
            2'd0: mResp = busWdata;
            2'd1: mPar = busWdata;
            default: postArm = postK;
          endcase
        end else if (busAddr == 2'd0) begin
          if (rdCount < 32) rdCyc[rdCount] = cyc;
          rdCount = rdCount + 1;
          if (preArm != 0) begin
            preArm = preArm - 1;
            if (preArm == 0) mResp = preVal;
          end else if (postArm != 0) begin
            postArm = postArm - 1;
            if (postArm == 0) begin
              mResp = fwResp;
              mPar = fwReply;
            end
          end
          busRdata <= mResp;
        end else begin
          busRdata <= mPar;
        end
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // one request; readiness poll armed by preArmV/preValV, completion answered on read postKV
  task automatic run(input string tag, input logic [7:0] id, input logic [31:0] par,
                     input logic [31:0] startResp, input int preArmV, input logic [31:0] preValV,
                     input int postKV, input logic [31:0] fwRespV, input logic [31:0] fwReplyV,
                     input logic nt, input logic [7:0] expSt, input logic [31:0] expRep,
                     input int expWr, input int expRd);
    int waitCyc;
    logic [7:0]  st;
    logic [31:0] rep;
    @(negedge clk);
    mResp = startResp; preArm = preArmV; preVal = preValV;
    postK = postKV; postArm = 0; fwResp = fwRespV; fwReply = fwReplyV;
    rdCount = 0; wrCount = 0; noTimeout = nt;
    reqId = id; reqParam = par; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R1", {tag, " ready low after accept"}, 32'(reqReady), 32'd0);
    waitCyc = 0;
    while (!doneOut && waitCyc < 3000) begin
      @(negedge clk);
      waitCyc = waitCyc + 1;
    end
    if (!doneOut) begin
      failures = failures + 1;
      $display("FAIL %s no done pulse actual=0 expected=1", tag);
      return;
    end
    st = statusOut; rep = replyOut;
    @(negedge clk);
    chk("R1", {tag, " done single cycle"}, 32'(doneOut), 32'd0);
    chk("R1", {tag, " ready back"}, 32'(reqReady), 32'd1);
    chk(tag, "status", 32'(st), 32'(expSt));
    chk(tag, "reply", rep, expRep);
    chk(tag, "bus writes", 32'(wrCount), 32'(expWr));
    chk(tag, "response reads", 32'(rdCount), 32'(expRd));
    noTimeout = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "reset ready", 32'(reqReady), 32'd1);
    chk("R1", "reset done", 32'(doneOut), 32'd0);
    chk("R1", "reset busReq", 32'(busReq), 32'd0);
  endtask

  task automatic t_normal;  // R5 R10
    run("R10 normal", 8'h15, 32'h0000_0700, 32'd1, 0, 0, 3, 32'd1, 32'h0000_ABCD, 1'b0,
        8'h01, 32'h0000_ABCD, 3, 4);
    chk("R5", "write0 addr", 32'(wrAddr[0]), 32'd0);
    chk("R5", "write0 data", wrData[0], 32'd0);
    chk("R5", "write1 addr", 32'(wrAddr[1]), 32'd1);
    chk("R5", "write1 data", wrData[1], 32'h0000_0700);
    chk("R5", "write2 addr", 32'(wrAddr[2]), 32'd2);
    chk("R5", "write2 data", wrData[2], 32'h15);
  endtask

  task automatic t_bad_id;  // R2
    run("R2 id0", 8'h00, 32'h1234, 32'd1, 0, 0, 1, 32'd1, 32'h9, 1'b0, 8'hFE, 32'd0, 0, 0);
    run("R2 id1E", 8'h1E, 32'h1234, 32'd1, 0, 0, 1, 32'd1, 32'h9, 1'b0, 8'hFE, 32'd0, 0, 0);
    run("R2 idFF", 8'hFF, 32'h1234, 32'd1, 0, 0, 1, 32'd1, 32'h9, 1'b0, 8'hFE, 32'd0, 0, 0);
  endtask

  task automatic t_pre_abort;  // R4 R7
    run("R4 pre busy", 8'h04, 32'h55, 32'd0, 0, 0, 1, 32'd1, 32'h9, 1'b0,
        8'h00, 32'd0, 0, RETRIES + 1);
    chk("R7", "poll interval", 32'(rdCyc[1] - rdCyc[0]), 32'(GAP + 2));
    chk("R7", "poll interval last", 32'(rdCyc[RETRIES] - rdCyc[RETRIES-1]), 32'(GAP + 2));
  endtask

  task automatic t_pre_edges;  // R3 R6
    run("R3 pre last read", 8'h1D, 32'h77, 32'd0, RETRIES + 1, 32'd1, 1, 32'd1, 32'h88, 1'b0,
        8'h01, 32'h88, 3, RETRIES + 2);
    run("R3 leftover code", 8'h02, 32'h10, 32'hFC, 0, 0, 2, 32'd1, 32'h4E, 1'b0,
        8'h01, 32'h4E, 3, 3);
    run("R6 post last read", 8'h07, 32'h3C, 32'd1, 0, 0, RETRIES + 1, 32'd1, 32'hC3, 1'b0,
        8'h01, 32'hC3, 3, RETRIES + 2);
  endtask

  task automatic t_fail;  // R9
    run("R9 fail", 8'h11, 32'h2, 32'd1, 0, 0, 2, 32'hFF, 32'hDEAD, 1'b0, 8'hFF, 32'd0, 4, 3);
    chk("R9", "ack write addr", 32'(wrAddr[3]), 32'd0);
    chk("R9", "ack write data", wrData[3], 32'd1);
  endtask

  task automatic t_extra_pass;  // R8 R10
    run("R8 extra pass", 8'h15, 32'h500, 32'd1, 0, 0, RETRIES + 2, 32'hFD, 32'h600, 1'b0,
        8'hFD, 32'h600, 3, RETRIES + 3);
    run("R8 full timeout", 8'h0A, 32'h321, 32'd1, 0, 0, 0, 32'd1, 32'h0, 1'b0,
        8'h00, 32'h321, 3, 2 * (RETRIES + 1) + 1);
  endtask

  task automatic t_no_timeout;  // R11
    run("R11 no timeout", 8'h13, 32'h0, 32'd0, 10, 32'd1, 6, 32'd1, 32'h258, 1'b1,
        8'h01, 32'h258, 3, 16);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures = failures + 1;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_bad_id();
    t_pre_abort();
    t_pre_edges();
    t_fail();
    t_extra_pass();
    t_no_timeout();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule